// File: doc/BRIEF.md
# Split-Side Multiplexed I/O Bus Port

This unit sits between a processor core and the external devices on an 8-bit bus that carries both addresses and data on the same wires. A side pin splits the device space into a left half (side 0) and a right half (side 1), so the bus reaches 512 byte locations. The core first sends an address command for one side. The unit drives that address with the address strobe and keeps the side pin there. Later write and read commands run data phases against that side.

A data access can cover the whole byte, a single bit, or a run of adjacent bits. Bit positions count from the most significant bit as bit 0. A write can rotate its source byte right before the low bits of the result go into the selected field. The bits outside the field come from a per-side shadow byte, so they keep their values. A read returns the selected field right-justified and zero-extended, plus a nonzero flag that a branch unit can test directly. Commands enter through a valid/ready channel. Read results leave through a second valid/ready channel. While a result waits for `rsp_ready`, no new command is accepted. `cmd_ready` is high only when the unit is idle, so a command that is offered stays offered until it is taken.

Top module: `iobus_port`

## Requirements
- R1: During and just after reset, `bus_astb`, `bus_dstb`, `bus_wr`, `bus_doe` and `rsp_valid` are low, `cmd_ready` is high and `bus_side` is 0 (left).
- R2: A command is taken on a rising edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while no bus phase runs and no read result is pending. `cmd_op` encodes 0 = address, 1 = write, 2 = read, 3 = no operation. A no-operation command is taken and causes no bus activity and no state change.
- R3: An address command drives one address phase in the cycle after acceptance, with `bus_astb`=1, `bus_doe`=1, `bus_dout`=`cmd_data` and `bus_side`=`cmd_side`. `bus_side` changes only when an address phase starts, so it stays stable through that phase and through every later data phase.
- R4: A write command drives one data phase in the cycle after acceptance, with `bus_dstb`=1, `bus_wr`=1, `bus_doe`=1 and `bus_dout` equal to the merged byte, on the last addressed side.
- R5: A read command drives one data phase in the cycle after acceptance, with `bus_dstb`=1, `bus_wr`=0 and `bus_doe`=0. `bus_din` is sampled at the end of that cycle, and `rsp_valid` rises in the next cycle.
- R6: Field selection: `cmd_pos` (3 bits) is the MSB-first index of the field's top bit (0 = byte MSB). `cmd_len` is the field width minus one. A field that would run past the LSB is cut at the LSB. `cmd_pos`=0 with `cmd_len`=7 selects the whole byte.
- R7: A write places the low bits of the rotated source into the selected field. All other bits of the written byte come from the shadow byte of that side.
- R8: Each side has its own shadow byte. It takes the byte read or written on that side. An address command that loads a different address on that side clears it to zero. An address command that loads the same address leaves it unchanged. All shadows and side addresses reset to zero.
- R9: A write rotates `cmd_data` right by `cmd_rot` before inserting it. On a read, `cmd_rot` has no effect.
- R10: `rsp_data` is the selected read field, right-justified and zero-extended. `rsp_nz` is 1 exactly when `rsp_data` is nonzero.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `cmd_ready` stays low. The result is consumed on the edge where `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 no operation |
| cmd_side | input | 1 | Side for an address command (0 left, 1 right) |
| cmd_data | input | 8 | Address byte or write source byte |
| cmd_pos | input | 3 | MSB-first index of the field's top bit |
| cmd_len | input | 3 | Field width minus one |
| cmd_rot | input | 3 | Right-rotate amount for a write source |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Core takes the read result |
| rsp_data | output | 8 | Right-justified read field |
| rsp_nz | output | 1 | Read field is nonzero |
| bus_dout | output | 8 | Address or data driven onto the bus |
| bus_doe | output | 1 | Unit drives the bus lines |
| bus_din | input | 8 | Data returned by the addressed device |
| bus_side | output | 1 | Side select, 0 left, 1 right |
| bus_astb | output | 1 | Address phase strobe |
| bus_dstb | output | 1 | Data phase strobe |
| bus_wr | output | 1 | Data phase is a write |

## Verification
All bus pins and handshake outputs come from registers. An address or write phase therefore shows in the cycle right after the accepting edge, and `cmd_ready` returns one cycle later. A read result appears two edges after acceptance and holds until the edge where `rsp_ready` is high. The bench samples every output at the falling edge and compares it with a behavioural model that advances on the same rising edges. That model includes the device memory and its latched per-side addresses. Each directed test also checks its read results against values worked out by hand from the field, rotate and shadow rules.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NOP   = 2'd3
  } iob_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_APH  = 3'd1,
    ST_WPH  = 3'd2,
    ST_RPH  = 3'd3,
    ST_RSP  = 3'd4
  } iob_state_e;

endpackage

// File: rtl/iob_rotr.sv
module iob_rotr #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [SW:0][W-1:0] stg;

  assign stg[0] = din;

  // log-depth barrel: stage s rotates right by 2**s when its amount bit is set
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = (1 << s) % W;
    logic [2*W-1:0] dbl;
    assign dbl        = {stg[s], stg[s]};
    assign stg[s + 1] = amt[s] ? dbl[SH +: W] : stg[s];
  end

  assign dout = stg[SW];

endmodule

// File: rtl/iob_field.sv
module iob_field #(
  parameter int W  = 8,
  parameter int PW = $clog2(W)
) (
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] len,
  input  logic [W-1:0]  shadow,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  bus_byte,
  output logic [W-1:0]  merged,
  output logic [W-1:0]  extracted
);

  localparam logic [PW-1:0] LAST = PW'(W - 1);

  logic [PW:0]   sum;
  logic [PW-1:0] hi;
  logic [PW-1:0] sh;
  logic [W-1:0]  mask;

  // last MSB-first index covered by the field, cut at the LSB
  assign sum = {1'b0, pos} + {1'b0, len};
  assign hi  = (sum > {1'b0, LAST}) ? LAST : sum[PW-1:0];
  assign sh  = LAST - hi;

  for (genvar i = 0; i < W; i++) begin : g_mask
    localparam logic [PW-1:0] J = PW'(W - 1 - i);
    assign mask[i] = (J >= pos) && (J <= hi);
  end

  assign merged    = ((src << sh) & mask) | (shadow & ~mask);
  assign extracted = (bus_byte & mask) >> sh;

endmodule

// File: rtl/iobus_port.sv
module iobus_port
  import iobus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic                   cmd_side,
  input  logic [DW-1:0]          cmd_data,
  input  logic [$clog2(DW)-1:0]  cmd_pos,
  input  logic [$clog2(DW)-1:0]  cmd_len,
  input  logic [$clog2(DW)-1:0]  cmd_rot,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DW-1:0]          rsp_data,
  output logic                   rsp_nz,
  output logic [DW-1:0]          bus_dout,
  output logic                   bus_doe,
  input  logic [DW-1:0]          bus_din,
  output logic                   bus_side,
  output logic                   bus_astb,
  output logic                   bus_dstb,
  output logic                   bus_wr
);

  localparam int PW    = $clog2(DW);
  localparam int SIDES = 2;

  iob_state_e    state;
  iob_op_e       op;
  logic          cur_side;
  logic [DW-1:0] side_addr [SIDES];
  logic [DW-1:0] shadow    [SIDES];
  logic [DW-1:0] dout_q;
  logic [DW-1:0] rsp_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] len_q;

  logic [DW-1:0] src_rot;
  logic [PW-1:0] f_pos;
  logic [PW-1:0] f_len;
  logic [DW-1:0] merged;
  logic [DW-1:0] extracted;

  assign op = iob_op_e'(cmd_op);

  iob_rotr #(.W(DW), .SW(PW)) u_rot (
    .din  (cmd_data),
    .amt  (cmd_rot),
    .dout (src_rot)
  );

  // one field unit serves both directions: command fields while idle,
  // held read fields during the read phase
  assign f_pos = (state == ST_RPH) ? pos_q : cmd_pos;
  assign f_len = (state == ST_RPH) ? len_q : cmd_len;

  iob_field #(.W(DW), .PW(PW)) u_field (
    .pos       (f_pos),
    .len       (f_len),
    .shadow    (shadow[cur_side]),
    .src       (src_rot),
    .bus_byte  (bus_din),
    .merged    (merged),
    .extracted (extracted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_side <= 1'b0;
      dout_q   <= '0;
      rsp_q    <= '0;
      pos_q    <= '0;
      len_q    <= '0;
      for (int s = 0; s < SIDES; s++) begin
        side_addr[s] <= '0;
        shadow[s]    <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (op)
              OP_ADDR: begin
                state               <= ST_APH;
                cur_side            <= cmd_side;
                dout_q              <= cmd_data;
                side_addr[cmd_side] <= cmd_data;
                if (cmd_data != side_addr[cmd_side]) shadow[cmd_side] <= '0;
              end
              OP_WRITE: begin
                state            <= ST_WPH;
                dout_q           <= merged;
                shadow[cur_side] <= merged;
              end
              OP_READ: begin
                state <= ST_RPH;
                pos_q <= cmd_pos;
                len_q <= cmd_len;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_APH, ST_WPH: state <= ST_IDLE;
        ST_RPH: begin
          shadow[cur_side] <= bus_din;
          rsp_q            <= extracted;
          state            <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_data  = rsp_q;
  assign rsp_nz    = |rsp_q;
  assign bus_dout  = dout_q;
  assign bus_side  = cur_side;
  assign bus_astb  = (state == ST_APH);
  assign bus_dstb  = (state == ST_WPH) || (state == ST_RPH);
  assign bus_wr    = (state == ST_WPH);
  assign bus_doe   = (state == ST_APH) || (state == ST_WPH);

  // R3: side pin moves only when an address phase begins
  a_r3_side_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_side) |-> bus_astb);

  // R3: address strobe lasts a single cycle and never overlaps a data phase
  a_r3_astb_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_astb |=> !bus_astb);
  a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_astb && bus_dstb));

  // R4: a write drives the bus during a data phase
  a_r4_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_dstb && bus_doe));

  // R5: read phase releases the bus and yields a result next cycle
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dstb && !bus_wr) |-> !bus_doe);
  a_r5_read_result: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dstb && !bus_wr) |=> rsp_valid);

  // R10: nonzero flag tracks the returned field
  a_r10_nz_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_nz == (rsp_data != '0)));

  // R11: held result stays put and blocks commands
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

endmodule

// File: tb/iobus_port_tb_top.sv
module iobus_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_side = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic [2:0] cmd_pos = 3'd0;
  logic [2:0] cmd_len = 3'd0;
  logic [2:0] cmd_rot = 3'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic       rsp_nz;
  logic [7:0] bus_dout;
  logic       bus_doe;
  logic [7:0] bus_din;
  logic       bus_side;
  logic       bus_astb;
  logic       bus_dstb;
  logic       bus_wr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  iobus_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_side(cmd_side), .cmd_data(cmd_data), .cmd_pos(cmd_pos),
    .cmd_len(cmd_len), .cmd_rot(cmd_rot),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_nz(rsp_nz),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_side(bus_side), .bus_astb(bus_astb), .bus_dstb(bus_dstb),
    .bus_wr(bus_wr)
  );

  // ---------------- device memory and reference model ----------------
  logic [7:0] mem [0:1][0:255];
  logic [7:0] dev_addr [0:1];

  int         ms;        // 0 idle, 1 addr, 2 write, 3 read, 4 result
  logic       m_side;
  logic [7:0] m_addr [0:1];
  logic [7:0] m_shadow [0:1];
  logic [7:0] m_dout;
  logic [7:0] m_rsp;
  logic [2:0] m_pos, m_len;

  assign bus_din = (bus_dstb && !bus_wr) ? mem[bus_side][dev_addr[bus_side]] : 8'h00;

  function automatic logic [7:0] f_init(input int s, input int a);
    return 8'((a * 7 + s * 91) & 255) ^ 8'h3C;
  endfunction

  function automatic int f_hi(input logic [2:0] p, input logic [2:0] l);
    return (int'(p) + int'(l) > 7) ? 7 : int'(p) + int'(l);
  endfunction

  function automatic logic [7:0] f_rot(input logic [7:0] v, input logic [2:0] r);
    logic [15:0] d;
    d = {v, v} >> r;
    return d[7:0];
  endfunction

  function automatic logic [7:0] f_ins(input logic [7:0] sh, input logic [7:0] src,
                                       input logic [2:0] p, input logic [2:0] l);
    logic [7:0] res;
    int hi;
    res = sh;
    hi  = f_hi(p, l);
    for (int j = int'(p); j <= hi; j++) res[7 - j] = src[hi - j];
    return res;
  endfunction

  function automatic logic [7:0] f_ext(input logic [7:0] b, input logic [2:0] p,
                                       input logic [2:0] l);
    logic [7:0] res;
    int hi;
    res = 8'h00;
    hi  = f_hi(p, l);
    for (int j = int'(p); j <= hi; j++) res[hi - j] = b[7 - j];
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 256; a++) mem[s][a] = f_init(s, a);
        dev_addr[s] = 8'h00;
        m_addr[s]   = 8'h00;
        m_shadow[s] = 8'h00;
      end
      ms = 0; m_side = 1'b0; m_dout = 8'h00; m_rsp = 8'h00;
      m_pos = 3'd0; m_len = 3'd0;
    end else begin
      if (bus_astb) dev_addr[bus_side] = bus_dout;
      if (bus_dstb && bus_wr) mem[bus_side][dev_addr[bus_side]] = bus_dout;
      case (ms)
        0: if (cmd_valid) begin
          case (cmd_op)
            2'd0: begin
              ms = 1; m_side = cmd_side; m_dout = cmd_data;
              if (m_addr[cmd_side] != cmd_data) m_shadow[cmd_side] = 8'h00;
              m_addr[cmd_side] = cmd_data;
            end
            2'd1: begin
              ms = 2;
              m_dout = f_ins(m_shadow[m_side], f_rot(cmd_data, cmd_rot), cmd_pos, cmd_len);
              m_shadow[m_side] = m_dout;
            end
            2'd2: begin ms = 3; m_pos = cmd_pos; m_len = cmd_len; end
            default: ms = 0;
          endcase
        end
        1, 2: ms = 0;
        3: begin
          m_shadow[m_side] = mem[m_side][m_addr[m_side]];
          m_rsp = f_ext(m_shadow[m_side], m_pos, m_len);
          ms = 4;
        end
        default: if (rsp_ready) ms = 0;
      endcase
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(cmd_ready == 1'b1, "R1 cmd_ready", {7'd0, cmd_ready}, 8'd1);
        chk({bus_astb, bus_dstb, bus_wr, bus_doe, rsp_valid, bus_side} == 6'd0,
            "R1 idle pins", {2'd0, bus_astb, bus_dstb, bus_wr, bus_doe, rsp_valid, bus_side}, 8'd0);
      end else begin
        chk(cmd_ready == (ms == 0), "R2 cmd_ready", {7'd0, cmd_ready}, {7'd0, ms == 0});
        chk(bus_astb == (ms == 1), "R3 bus_astb", {7'd0, bus_astb}, {7'd0, ms == 1});
        chk(bus_side == m_side, "R3 bus_side", {7'd0, bus_side}, {7'd0, m_side});
        chk(bus_wr == (ms == 2), "R4 bus_wr", {7'd0, bus_wr}, {7'd0, ms == 2});
        chk(bus_dstb == (ms == 2 || ms == 3), "R5 bus_dstb", {7'd0, bus_dstb},
            {7'd0, ms == 2 || ms == 3});
        chk(bus_doe == (ms == 1 || ms == 2), "R5 bus_doe", {7'd0, bus_doe},
            {7'd0, ms == 1 || ms == 2});
        if (ms == 1 || ms == 2) chk(bus_dout == m_dout, "R7 bus_dout", bus_dout, m_dout);
        chk(rsp_valid == (ms == 4), "R11 rsp_valid", {7'd0, rsp_valid}, {7'd0, ms == 4});
        if (ms == 4) begin
          chk(rsp_data == m_rsp, "R10 rsp_data", rsp_data, m_rsp);
          chk(rsp_nz == (m_rsp != 0), "R10 rsp_nz", {7'd0, rsp_nz}, {7'd0, m_rsp != 0});
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic s, input logic [7:0] d,
                      input logic [2:0] p, input logic [2:0] l, input logic [2:0] r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_side = s; cmd_data = d;
    cmd_pos = p; cmd_len = l; cmd_rot = r;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_rsp(input logic [7:0] exp, input string tag);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == exp, tag, rsp_data, exp);
    chk(rsp_nz == (exp != 0), tag, {7'd0, rsp_nz}, {7'd0, exp != 0});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic rd(input logic [2:0] p, input logic [2:0] l, input logic [2:0] r,
                    input logic [7:0] exp, input string tag);
    send(2'd2, 1'b0, 8'h00, p, l, r);
    get_rsp(exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid && !bus_astb && !bus_dstb, "R1 after reset",
        {7'd0, cmd_ready}, 8'd1);

    // whole-byte write then read, left side
    send(2'd0, 1'b0, 8'h12, 3'd0, 3'd0, 3'd0);
    chk(bus_side == 1'b0, "R3 side left", {7'd0, bus_side}, 8'd0);
    send(2'd1, 1'b0, 8'hA5, 3'd0, 3'd7, 3'd0);
    rd(3'd0, 3'd7, 3'd0, 8'hA5, "R4 whole write readback");

    // same address on the right side keeps halves apart
    send(2'd0, 1'b1, 8'h12, 3'd0, 3'd0, 3'd0);
    chk(bus_side == 1'b1, "R3 side right", {7'd0, bus_side}, 8'd1);
    send(2'd1, 1'b0, 8'h3C, 3'd0, 3'd7, 3'd0);
    rd(3'd0, 3'd7, 3'd0, 8'h3C, "R5 right readback");

    // same address reload keeps shadow; field write of 6 into MSB-bits 1..3
    send(2'd0, 1'b0, 8'h12, 3'd0, 3'd0, 3'd0);
    send(2'd1, 1'b0, 8'h06, 3'd1, 3'd2, 3'd0);
    rd(3'd0, 3'd7, 3'd0, 8'hE5, "R7 R8 field merge");

    // field and single-bit reads
    rd(3'd1, 3'd2, 3'd0, 8'h06, "R10 field read");
    rd(3'd7, 3'd0, 3'd0, 8'h01, "R6 bit LSB read");
    rd(3'd3, 3'd0, 3'd0, 8'h00, "R10 zero bit nz");

    // new address clears shadow
    send(2'd0, 1'b0, 8'h40, 3'd0, 3'd0, 3'd0);
    send(2'd1, 1'b0, 8'h01, 3'd0, 3'd0, 3'd0);
    rd(3'd0, 3'd7, 3'd0, 8'h80, "R8 shadow cleared");

    // rotate on writes, ignored on reads
    send(2'd1, 1'b0, 8'h03, 3'd0, 3'd7, 3'd1);
    rd(3'd0, 3'd7, 3'd0, 8'h81, "R9 rotate by 1");
    send(2'd1, 1'b0, 8'h0F, 3'd0, 3'd7, 3'd3);
    rd(3'd0, 3'd7, 3'd5, 8'hE1, "R9 rotate by 3, read unrotated");

    // clipped field at the LSB
    send(2'd1, 1'b0, 8'hFF, 3'd6, 3'd5, 3'd0);
    rd(3'd0, 3'd7, 3'd0, 8'hE3, "R6 clipped field");

    // no-operation has no effect
    send(2'd3, 1'b1, 8'hFF, 3'd0, 3'd7, 3'd0);
    chk(bus_side == 1'b0, "R2 nop side", {7'd0, bus_side}, 8'd0);
    rd(3'd0, 3'd7, 3'd0, 8'hE3, "R2 nop no change");

    // preloaded device byte on the right, with back-pressure
    send(2'd0, 1'b1, 8'h77, 3'd0, 3'd0, 3'd0);
    send(2'd2, 1'b0, 8'h00, 3'd0, 3'd7, 3'd0);
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1'b1, "R11 held valid", {7'd0, rsp_valid}, 8'd1);
    chk(cmd_ready == 1'b0, "R11 blocked", {7'd0, cmd_ready}, 8'd0);
    get_rsp(f_init(1, 8'h77), "R11 R5 preload read");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule